// File: doc/BRIEF.md
# Sub-vector swizzle unit with constant substitution

The unit rebuilds one destination sub-vector from one source sub-vector, one outer vector element per accepted request. A selector word carries one 3-bit field for each destination lane. A field either names a source lane, or substitutes one of four fixed values that depend on the element type. The element type is either 8-bit or 16-bit integer. The destination length and the source length, each from 1 to 4 lanes, come in with every request. The outer vector loop and the register file sit outside the unit. The surrounding sequencer places destination lane i of outer element v at position v×dst_len+i, and it supplies the source lanes starting at position v×src_len.

The result is registered. It appears one clock after the request, together with per-lane write enables and an illegal-instruction flag. An illegal selector raises the flag and writes nothing for that element.

Top module: `swz_unit`

## Requirements
- R1: After synchronous reset, out_valid, out_trap, out_we and out_lanes are all zero.
- R2: out_valid is high in the cycle after each cycle in which in_valid was high, and low in any other cycle.
- R3: Destination lane i is controlled by selector bits [3i+2:3i]. When bit 2 of that field is 0, bits [1:0] give the source lane that is copied into destination lane i. Lanes are packed with lane k at bits [16k+15:16k].
- R4: In 8-bit mode (in_wide=0), a field with bit 2 set gives a constant chosen by bits [1:0]: index 0 gives 0x00, 1 gives 0x01, 2 gives 0xFF, 3 gives 0x7F.
- R5: In 16-bit mode (in_wide=1), a field with bit 2 set gives a constant chosen by bits [1:0]: index 0 gives 0x0000, 1 gives 0x0001, 2 gives 0xFFFF, 3 gives 0x7FFF.
- R6: In 8-bit mode, a copied source lane contributes only its low 8 bits, and bits [15:8] of every output lane are zero.
- R7: If any selector bit at position 3×in_dst_len or above is set, out_trap is raised for that element. This includes the bits above the four fields.
- R8: If the 2-bit index of any active field (lane below in_dst_len) is greater than or equal to in_src_len, out_trap is raised, even when bit 2 selects a constant.
- R9: When out_trap is high, every bit of out_we is zero.
- R10: For a legal element, out_we bit i is 1 exactly for the lanes i below in_dst_len.
- R11: In a cycle after in_valid was low, out_we and out_trap are zero and out_lanes keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request for one outer element |
| in_src | input | 64 | Source sub-vector, lane k at [16k+15:16k] |
| in_sel | input | 16 | Selector word, 3-bit field per destination lane |
| in_dst_len | input | 3 | Destination sub-vector length, 1 to 4 |
| in_src_len | input | 3 | Source sub-vector length, 1 to 4 |
| in_wide | input | 1 | Element type: 0 = 8-bit, 1 = 16-bit |
| out_valid | output | 1 | Result valid |
| out_lanes | output | 64 | Destination sub-vector |
| out_we | output | 4 | Per-lane write enables |
| out_trap | output | 1 | Illegal-instruction flag |

## Verification
The properties assume that both length inputs stay within 1 to 4 whenever in_valid is high. A length of zero or above four has no defined meaning for the lane-count relation. Every directed request in the bench uses lengths in that range and moves between 1, 2 and 4. While in_valid is low, the bench changes the selector and the data freely, which shows that idle cycles do not disturb the held result.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int FIELD_W  = 3;
  localparam int IDX_W    = FIELD_W - 1;
  localparam int NARROW_W = 8;
  localparam int CONST_W  = 16;

  typedef enum logic {
    EW_BYTE = 1'b0,
    EW_HALF = 1'b1
  } elem_kind_e;

  function automatic logic [CONST_W-1:0] fixed_value(input elem_kind_e kind,
                                                     input logic [IDX_W-1:0] pick);
    logic [CONST_W-1:0] v;
    case (pick)
      2'd0:    v = '0;
      2'd1:    v = CONST_W'(1);
      2'd2:    v = (kind == EW_HALF) ? 16'hFFFF : 16'h00FF;
      default: v = (kind == EW_HALF) ? 16'h7FFF : 16'h007F;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/swz_field_dec.sv
module swz_field_dec
  import swz_pkg::*;
#(
  parameter int LEN_W = 3,
  parameter int LANE  = 0
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [LEN_W-1:0]   dst_len,
  input  logic [LEN_W-1:0]   src_len,
  output logic               use_const,
  output logic [IDX_W-1:0]   idx,
  output logic               active,
  output logic               bad_idx
);
  always_comb begin
    use_const = field[FIELD_W-1];
    idx       = field[IDX_W-1:0];
    active    = (LEN_W'(LANE) < dst_len);
    // range check applies to constant picks as well
    bad_idx   = active && (LEN_W'(idx) >= src_len);
  end
endmodule

// File: rtl/swz_legal.sv
module swz_legal
  import swz_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int NLANES = 4,
  parameter int LEN_W  = 3
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [LEN_W-1:0]  dst_len,
  input  logic [NLANES-1:0] bad_idx,
  output logic              illegal
);
  logic [SEL_W-1:0] beyond;

  for (genvar b = 0; b < SEL_W; b++) begin : g_bit
    // bit b belongs to field b/FIELD_W; beyond the active fields it must be clear
    assign beyond[b] = (int'(b / FIELD_W) >= int'(dst_len));
  end

  assign illegal = (|(sel & beyond)) | (|bad_idx);
endmodule

// File: rtl/swz_lane_mux.sv
module swz_lane_mux
  import swz_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int ELEM_W = 16
) (
  input  logic [NLANES*ELEM_W-1:0] src,
  input  logic                     use_const,
  input  logic [IDX_W-1:0]         idx,
  input  elem_kind_e               kind,
  output logic [ELEM_W-1:0]        elem
);
  localparam logic [ELEM_W-1:0] NARROW_MASK = ELEM_W'((1 << NARROW_W) - 1);

  logic [ELEM_W-1:0] picked;
  logic [ELEM_W-1:0] lane_val;

  always_comb begin
    lane_val = '0;
    for (int k = 0; k < NLANES; k++) begin
      if (int'(idx) == k) lane_val = src[k*ELEM_W +: ELEM_W];
    end
    picked = use_const ? ELEM_W'(fixed_value(kind, idx)) : lane_val;
    elem   = (kind == EW_HALF) ? picked : (picked & NARROW_MASK);
  end
endmodule

// File: rtl/swz_unit.sv
module swz_unit
  import swz_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int ELEM_W = 16,
  parameter int SEL_W  = 16,
  localparam int LEN_W = $clog2(NLANES + 1),
  localparam int VEC_W = NLANES * ELEM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_src,
  input  logic [SEL_W-1:0]  in_sel,
  input  logic [LEN_W-1:0]  in_dst_len,
  input  logic [LEN_W-1:0]  in_src_len,
  input  logic              in_wide,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_lanes,
  output logic [NLANES-1:0] out_we,
  output logic              out_trap
);
  elem_kind_e        kind;
  logic [NLANES-1:0] lane_active;
  logic [NLANES-1:0] lane_bad;
  logic [VEC_W-1:0]  nxt_lanes;
  logic              nxt_trap;

  assign kind = elem_kind_e'(in_wide);

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic             use_const;
    logic [IDX_W-1:0] idx;

    swz_field_dec #(.LEN_W(LEN_W), .LANE(i)) u_dec (
      .field     (in_sel[i*FIELD_W +: FIELD_W]),
      .dst_len   (in_dst_len),
      .src_len   (in_src_len),
      .use_const (use_const),
      .idx       (idx),
      .active    (lane_active[i]),
      .bad_idx   (lane_bad[i])
    );

    swz_lane_mux #(.NLANES(NLANES), .ELEM_W(ELEM_W)) u_mux (
      .src       (in_src),
      .use_const (use_const),
      .idx       (idx),
      .kind      (kind),
      .elem      (nxt_lanes[i*ELEM_W +: ELEM_W])
    );
  end

  swz_legal #(.SEL_W(SEL_W), .NLANES(NLANES), .LEN_W(LEN_W)) u_legal (
    .sel     (in_sel),
    .dst_len (in_dst_len),
    .bad_idx (lane_bad),
    .illegal (nxt_trap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lanes <= '0;
      out_we    <= '0;
      out_trap  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_lanes <= nxt_lanes;
        out_trap  <= nxt_trap;
        out_we    <= nxt_trap ? '0 : lane_active;
      end else begin
        out_we    <= '0;
        out_trap  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swz_unit_chk.sv
module swz_unit_chk #(
  parameter int NLANES = 4,
  parameter int ELEM_W = 16,
  parameter int SEL_W  = 16,
  parameter int LEN_W  = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [SEL_W-1:0]         in_sel,
  input logic [LEN_W-1:0]         in_dst_len,
  input logic                     in_wide,
  input logic                     out_valid,
  input logic [NLANES*ELEM_W-1:0] out_lanes,
  input logic [NLANES-1:0]        out_we,
  input logic                     out_trap
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r7_high_bits_trap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ((in_sel >> (3 * in_dst_len)) != '0)) |=> out_trap);
  a_r9_trap_no_write: assert property (@(posedge clk) disable iff (rst)
    out_trap |-> (out_we == '0));
  a_r10_lane_count: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_trap) |-> ($countones(out_we) == int'($past(in_dst_len))));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_we == '0 && !out_trap));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_lanes));

  for (genvar i = 0; i < NLANES; i++) begin : g_narrow
    a_r6_upper_clear: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !$past(in_wide)) |-> (out_lanes[i*ELEM_W+8 +: ELEM_W-8] == '0));
  end
endmodule

bind swz_unit swz_unit_chk #(.NLANES(NLANES), .ELEM_W(ELEM_W), .SEL_W(SEL_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_sel     (in_sel),
  .in_dst_len (in_dst_len),
  .in_wide    (in_wide),
  .out_valid  (out_valid),
  .out_lanes  (out_lanes),
  .out_we     (out_we),
  .out_trap   (out_trap)
);

// File: tb/sim_swz_unit.sv
`timescale 1ns/1ps
module sim_swz_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] in_src;
  logic [15:0] in_sel;
  logic [2:0]  in_dst_len;
  logic [2:0]  in_src_len;
  logic        in_wide;
  logic        out_valid;
  logic [63:0] out_lanes;
  logic [3:0]  out_we;
  logic        out_trap;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  swz_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_sel(in_sel),
    .in_dst_len(in_dst_len), .in_src_len(in_src_len), .in_wide(in_wide),
    .out_valid(out_valid), .out_lanes(out_lanes), .out_we(out_we), .out_trap(out_trap)
  );

  function automatic logic [15:0] mk_sel(input logic [2:0] f0, f1, f2, f3,
                                         input logic [3:0] hi);
    return {hi, f3, f2, f1, f0};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // drive one request at the falling edge, sample one edge later, off the edge
  task automatic issue(input logic v, input logic [63:0] src, input logic [15:0] sel,
                       input logic [2:0] dl, input logic [2:0] sl, input logic wide);
    @(negedge clk);
    in_valid = v; in_src = src; in_sel = sel;
    in_dst_len = dl; in_src_len = sl; in_wide = wide;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  localparam logic [63:0] SRC_A = {16'h4444, 16'h3333, 16'h2222, 16'h1111};

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_src = '0; in_sel = '0;
    in_dst_len = 3'd4; in_src_len = 3'd4; in_wide = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 we",    {60'd0, out_we},    64'd0);
    chk("R1 trap",  {63'd0, out_trap},  64'd0);
    chk("R1 lanes", out_lanes,          64'd0);
  endtask

  task automatic t_reverse();
    issue(1'b1, SRC_A, mk_sel(3'd3, 3'd2, 3'd1, 3'd0, 4'h0), 3'd4, 3'd4, 1'b1);
    chk("R2 valid", {63'd0, out_valid}, 64'd1);
    chk("R3 reverse", out_lanes, {16'h1111, 16'h2222, 16'h3333, 16'h4444});
    chk("R10 we full", {60'd0, out_we}, 64'hF);
    chk("R3 trap", {63'd0, out_trap}, 64'd0);
  endtask

  task automatic t_const8();
    issue(1'b1, SRC_A, mk_sel(3'd4, 3'd5, 3'd6, 3'd7, 4'h0), 3'd4, 3'd4, 1'b0);
    chk("R4 consts", out_lanes, {16'h007F, 16'h00FF, 16'h0001, 16'h0000});
    chk("R4 trap", {63'd0, out_trap}, 64'd0);
  endtask

  task automatic t_const16();
    issue(1'b1, SRC_A, mk_sel(3'd7, 3'd6, 3'd5, 3'd4, 4'h0), 3'd4, 3'd4, 1'b1);
    chk("R5 consts", out_lanes, {16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF});
  endtask

  task automatic t_narrow();
    issue(1'b1, {16'h9A78, 16'hEF56, 16'hCD34, 16'hAB12},
          mk_sel(3'd0, 3'd1, 3'd3, 3'd2, 4'h0), 3'd4, 3'd4, 1'b0);
    chk("R6 narrow", out_lanes, {16'h0056, 16'h0078, 16'h0034, 16'h0012});
  endtask

  task automatic t_partial();
    issue(1'b1, SRC_A, mk_sel(3'd2, 3'd3, 3'd0, 3'd0, 4'h0), 3'd2, 3'd4, 1'b1);
    chk("R10 we two", {60'd0, out_we}, 64'h3);
    chk("R10 lanes", out_lanes[31:0], {16'h4444, 16'h3333});
    chk("R10 trap", {63'd0, out_trap}, 64'd0);
  endtask

  task automatic t_high_bits();
    issue(1'b1, SRC_A, mk_sel(3'd0, 3'd1, 3'd1, 3'd0, 4'h0), 3'd2, 3'd4, 1'b1);
    chk("R7 field beyond len", {63'd0, out_trap}, 64'd1);
    chk("R9 we off", {60'd0, out_we}, 64'd0);
    issue(1'b1, SRC_A, mk_sel(3'd0, 3'd1, 3'd2, 3'd3, 4'h8), 3'd4, 3'd4, 1'b1);
    chk("R7 top bit", {63'd0, out_trap}, 64'd1);
    chk("R9 we off top", {60'd0, out_we}, 64'd0);
  endtask

  task automatic t_range();
    issue(1'b1, SRC_A, mk_sel(3'd0, 3'd3, 3'd0, 3'd0, 4'h0), 3'd4, 3'd2, 1'b1);
    chk("R8 lane range", {63'd0, out_trap}, 64'd1);
    issue(1'b1, SRC_A, mk_sel(3'd6, 3'd0, 3'd0, 3'd0, 4'h0), 3'd4, 3'd2, 1'b1);
    chk("R8 const range", {63'd0, out_trap}, 64'd1);
    issue(1'b1, SRC_A, mk_sel(3'd1, 3'd5, 3'd0, 3'd1, 4'h0), 3'd4, 3'd2, 1'b1);
    chk("R8 legal", {63'd0, out_trap}, 64'd0);
    chk("R8 lanes", out_lanes, {16'h2222, 16'h1111, 16'h0001, 16'h2222});
    issue(1'b1, SRC_A, mk_sel(3'd1, 3'd0, 3'd0, 3'd0, 4'h0), 3'd1, 3'd1, 1'b1);
    chk("R8 single lane", {63'd0, out_trap}, 64'd1);
  endtask

  task automatic t_idle();
    logic [63:0] held;
    issue(1'b1, SRC_A, mk_sel(3'd1, 3'd1, 3'd1, 3'd1, 4'h0), 3'd4, 3'd2, 1'b1);
    chk("R3 broadcast", out_lanes, {4{16'h2222}});
    held = out_lanes;
    issue(1'b0, ~SRC_A, 16'hFFFF, 3'd1, 3'd1, 1'b0);
    chk("R2 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R11 we", {60'd0, out_we}, 64'd0);
    chk("R11 trap", {63'd0, out_trap}, 64'd0);
    chk("R11 hold", out_lanes, held);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_reverse();
    t_const8();
    t_const16();
    t_narrow();
    t_partial();
    t_high_bits();
    t_range();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule